// File: doc/BRIEF.md
# Single-Wire Byte Bus Master

This block is a register-mapped master for a byte-oriented serial bus that runs over one open-drain wire. Software loads a byte, picks an operation through three control bits, and sets a self-clearing start bit. The block then generates the bus waveform, or samples a slave's waveform. It records the outcome in sticky status flags and raises a level interrupt. Three operations exist: a long low pulse that initialises the slave, a byte write, and a byte read.

The wire is driven only low. `line_oe` pulls the wire down, and `line_in` returns the wire level through a synchronizer. All bus timing is set by parameters in microseconds and scaled by the number of functional clock cycles per microsecond. With the default of one cycle per microsecond, a bit slot is 200 cycles. A data one is driven low for 40 cycles and a data zero for 140 cycles. The initialisation pulse is 190 cycles low, followed by 40 cycles of recovery. Bytes travel least significant bit first.

Top module: `slw_master`

## Requirements
- R1: After reset the revision register (offset 0x00) reads REV_MAJOR in bits 7:4 and REV_MINOR in bits 3:0 (default 0x21). Control (0x0C), flags (0x10), transmit data (0x04) and configuration (0x14) read 0. `irq` and `line_oe` are 0, and status (0x18) bit 0 reads 1.
- R2: A control write with bit 2 (init), bit 4 (start) and bit 5 (clock enable) set drives the wire low for 190 cycles, starting the cycle after the write. It then releases the wire for 40 cycles. Next it sets flag bit 0 (timeout) and clears control bits 2 and 4.
- R3: A control write with bits 4 and 5 set and bits 1 and 2 clear sends the byte from offset 0x04, least significant bit first. It uses one 200-cycle slot per bit, driven low for 40 cycles for a 1 and 140 cycles for a 0, with the first slot starting the cycle after the write. Afterwards it sets flag bit 2 (transmit complete) and clears control bit 4.
- R4: A control write with bits 1 (read), 4 and 5 set receives eight bits, least significant first. Each bit starts when the slave pulls the wire low, and the wire is sampled 100 cycles after the synchronized falling edge. The block then sets flag bit 1 (receive complete), places the byte at offset 0x08, clears control bit 4 and keeps bit 1.
- R5: During a read, if the wire is not pulled low within 500 cycles, the block sets flag bit 0 instead of bit 1 and clears control bit 4. With `irq` enabled, `irq` is 0 in the 500th cycle after the write and 1 in the 501st.
- R6: Flags are sticky and accumulate across operations. A read of offset 0x10 returns them and clears them. A flag raised in the same cycle as that read survives it.
- R7: `irq` is 1 exactly when some flag is set and control bit 6 (interrupt enable) is 1. Setting bit 6 while flags are pending raises `irq` at once.
- R8: A start request written with control bit 5 clear is ignored. Control bit 4 reads 0 and the wire stays released.
- R9: A control write while an operation runs leaves control bits 1, 2 and 4 and the waveform on the wire unchanged.
- R10: Writing 1 to configuration bit 1 clears all registers and aborts any operation, so the wire is released in the next cycle. Status bit 0 reads 0 in that cycle and 1 from the next, and configuration bit 1 always reads 0.
- R11: Configuration bit 0 (auto-idle) is stored and reads back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears flags on offset 0x10) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| line_oe | output | 1 | Pull the bus wire low when 1 |
| line_in | input | 1 | Level of the bus wire |
| irq | output | 1 | Level interrupt request |

## Verification
On every cycle the assertions check the following:
- the wire is pulled low only while the start bit is set;
- a start request without clock enable is refused, and writes during a transfer leave the start and init bits alone;
- a plain flag read empties the flags;
- the end of an initialisation pulse sets the timeout flag and clears init and start;
- a soft reset leaves control, flags and the wire idle.

Only the bench scenarios can show the exact waveform timing and the bit order of written and read bytes. The same holds for the exact cycle a read timeout fires, a flag raised in the same cycle as a read surviving it, interrupt masking with pending flags, and the reset-done timing.

// File: rtl/slw_pkg.sv
// Shared register offsets, bit positions and state types for the
// single-wire byte bus master. Assumes byte-wide registers on a 5-bit offset.
package slw_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_REV = 5'h00;
    localparam logic [ADDR_W-1:0] A_TXD = 5'h04;
    localparam logic [ADDR_W-1:0] A_RXD = 5'h08;
    localparam logic [ADDR_W-1:0] A_CTL = 5'h0C;
    localparam logic [ADDR_W-1:0] A_FLG = 5'h10;
    localparam logic [ADDR_W-1:0] A_CFG = 5'h14;
    localparam logic [ADDR_W-1:0] A_STA = 5'h18;

    localparam int B_MODE  = 0;
    localparam int B_DIR   = 1;
    localparam int B_INIT  = 2;
    localparam int B_GO    = 4;
    localparam int B_CLKEN = 5;
    localparam int B_IEN   = 6;

    localparam int F_TMO = 0;
    localparam int F_RXC = 1;
    localparam int F_TXC = 2;

    localparam int C_IDLE = 0;
    localparam int C_SRST = 1;

    typedef enum logic [1:0] {XF_NONE, XF_BRK, XF_TX, XF_RX} xfer_e;
    typedef enum logic [2:0] {S_IDLE, S_BRK, S_TX, S_RX_LOW, S_RX_SMP, S_RX_HIGH} seq_state_e;
endpackage

// File: rtl/slw_sync.sv
// Multi-stage synchronizer for the bus wire level.
// Assumes the wire idles high, so every stage resets to 1.
module slw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] stg_q;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            // Each stage copies its predecessor; stage 0 takes the raw wire.
            always_ff @(posedge clk) begin
                if (!rst_n)      stg_q[i] <= 1'b1;
                else if (i == 0) stg_q[i] <= d_in;
                else             stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign d_out = stg_q[STAGES-1];
endmodule

// File: rtl/slw_regs.sv
// Register file: decodes byte accesses, turns start requests into a
// one-cycle start kind for the sequencer, keeps sticky flags cleared on read,
// and generates the soft reset. Assumes the sequencer reports each ending
// with exactly one event pulse while the start bit is set.
module slw_regs
    import slw_pkg::*;
#(
    parameter logic [7:0] REV_ID = 8'h21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              ev_brk,
    input  logic              ev_tx,
    input  logic              ev_rx,
    input  logic              ev_rxto,
    input  logic [7:0]        rx_byte,
    output xfer_e             start_kind,
    output logic [7:0]        tx_byte,
    output logic [7:0]        ctl_q,
    output logic [2:0]        flags_q,
    output logic              soft_rst,
    output logic              irq
);
    logic       hit_ctl;
    logic       go_req;
    logic [7:0] rx_q;
    logic       idle_q;
    logic       rst_done_q;
    logic [2:0] ev_vec;

    assign hit_ctl  = reg_wr && (reg_addr == A_CTL);
    assign soft_rst = reg_wr && (reg_addr == A_CFG) && reg_wdata[C_SRST];
    assign ev_vec   = {ev_tx, ev_rx, ev_brk | ev_rxto};

    // Accept a start only with clock enable in the same write and nothing running.
    assign go_req = hit_ctl && reg_wdata[B_GO] && reg_wdata[B_CLKEN] && !ctl_q[B_GO];

    // Select the operation: init beats read direction, which beats write.
    always_comb begin
        if (!go_req)                 start_kind = XF_NONE;
        else if (reg_wdata[B_INIT])  start_kind = XF_BRK;
        else if (reg_wdata[B_DIR])   start_kind = XF_RX;
        else                         start_kind = XF_TX;
    end

    // Control register: free bits always writable, operation bits frozen while busy.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctl_q <= '0;
        end else begin
            if (hit_ctl) begin
                ctl_q[B_MODE]  <= reg_wdata[B_MODE];
                ctl_q[B_CLKEN] <= reg_wdata[B_CLKEN];
                ctl_q[B_IEN]   <= reg_wdata[B_IEN];
                if (!ctl_q[B_GO]) begin
                    ctl_q[B_DIR]  <= reg_wdata[B_DIR];
                    ctl_q[B_INIT] <= reg_wdata[B_INIT];
                    ctl_q[B_GO]   <= go_req;
                end
            end
            if (ev_tx || ev_rx || ev_rxto) ctl_q[B_GO] <= 1'b0;
            if (ev_brk) begin
                ctl_q[B_GO]   <= 1'b0;
                ctl_q[B_INIT] <= 1'b0;
            end
        end
    end

    // Sticky flags: a read clears them, but a new event in that cycle survives.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            flags_q <= '0;
        else if (reg_rd && (reg_addr == A_FLG))
            flags_q <= ev_vec;
        else
            flags_q <= flags_q | ev_vec;
    end

    // Data and configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            tx_byte <= '0;
            rx_q    <= '0;
            idle_q  <= 1'b0;
        end else begin
            if (reg_wr && (reg_addr == A_TXD)) tx_byte <= reg_wdata;
            if (reg_wr && (reg_addr == A_CFG)) idle_q  <= reg_wdata[C_IDLE];
            if (ev_rx)                         rx_q    <= rx_byte;
        end
    end

    // Reset-done indicator: low for the cycle after any reset, then high.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) rst_done_q <= 1'b0;
        else                    rst_done_q <= 1'b1;
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_REV: reg_rdata = REV_ID;
            A_TXD: reg_rdata = tx_byte;
            A_RXD: reg_rdata = rx_q;
            A_CTL: reg_rdata = ctl_q;
            A_FLG: reg_rdata = {5'b0, flags_q};
            A_CFG: reg_rdata = {7'b0, idle_q};
            A_STA: reg_rdata = {7'b0, rst_done_q};
            default: reg_rdata = '0;
        endcase
    end

    assign irq = (|flags_q) && ctl_q[B_IEN];
endmodule

// File: rtl/slw_seq.sv
// Transaction sequencer: produces the init pulse and write slots on the
// open-drain wire, times and samples read slots, and reports each ending
// with a one-cycle event. Assumes line_s is already synchronized.
module slw_seq
    import slw_pkg::*;
#(
    parameter int BRK_LOW_CYC = 190,
    parameter int BRK_REC_CYC = 40,
    parameter int SLOT_CYC    = 200,
    parameter int LOW1_CYC    = 40,
    parameter int LOW0_CYC    = 140,
    parameter int SMP_CYC     = 100,
    parameter int RXWAIT_CYC  = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abort,
    input  xfer_e      start_kind,
    input  logic [7:0] tx_byte,
    input  logic       line_s,
    output logic       line_oe,
    output logic       ev_brk,
    output logic       ev_tx,
    output logic       ev_rx,
    output logic       ev_rxto,
    output logic [7:0] rx_byte
);
    localparam int TW = $clog2(BRK_LOW_CYC + BRK_REC_CYC + SLOT_CYC + SMP_CYC + RXWAIT_CYC + 2);
    localparam logic [TW-1:0] BRK_LAST  = TW'(BRK_LOW_CYC + BRK_REC_CYC - 1);
    localparam logic [TW-1:0] BRK_LOW   = TW'(BRK_LOW_CYC);
    localparam logic [TW-1:0] SLOT_LAST = TW'(SLOT_CYC - 1);
    localparam logic [TW-1:0] LOW1      = TW'(LOW1_CYC);
    localparam logic [TW-1:0] LOW0      = TW'(LOW0_CYC);
    localparam logic [TW-1:0] SMP_LAST  = TW'(SMP_CYC - 1);
    localparam logic [TW-1:0] WAIT_LAST = TW'(RXWAIT_CYC - 1);

    seq_state_e    state_q;
    logic [TW-1:0] timer_q;
    logic [2:0]    bit_q;
    logic [7:0]    shreg_q;

    // State, slot timer, bit counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state_q <= S_IDLE;
            timer_q <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    timer_q <= '0;
                    bit_q   <= '0;
                    case (start_kind)
                        XF_BRK: state_q <= S_BRK;
                        XF_TX: begin
                            state_q <= S_TX;
                            shreg_q <= tx_byte;
                        end
                        XF_RX:  state_q <= S_RX_LOW;
                        default: state_q <= S_IDLE;
                    endcase
                end
                S_BRK: begin
                    if (timer_q == BRK_LAST) state_q <= S_IDLE;
                    else                     timer_q <= timer_q + 1'b1;
                end
                S_TX: begin
                    if (timer_q == SLOT_LAST) begin
                        timer_q <= '0;
                        shreg_q <= shreg_q >> 1;
                        bit_q   <= bit_q + 1'b1;
                        if (bit_q == 3'd7) state_q <= S_IDLE;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                S_RX_LOW: begin
                    if (!line_s) begin
                        state_q <= S_RX_SMP;
                        timer_q <= '0;
                    end else if (timer_q == WAIT_LAST) begin
                        state_q <= S_IDLE;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                S_RX_SMP: begin
                    if (timer_q == SMP_LAST) begin
                        shreg_q <= {line_s, shreg_q[7:1]};
                        state_q <= S_RX_HIGH;
                        timer_q <= '0;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                S_RX_HIGH: begin
                    if (line_s) begin
                        timer_q <= '0;
                        bit_q   <= bit_q + 1'b1;
                        state_q <= (bit_q == 3'd7) ? S_IDLE : S_RX_LOW;
                    end else if (timer_q == WAIT_LAST) begin
                        state_q <= S_IDLE;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Wire drive: low phase of the init pulse or of the current write slot.
    always_comb begin
        case (state_q)
            S_BRK:   line_oe = (timer_q < BRK_LOW);
            S_TX:    line_oe = (timer_q < (shreg_q[0] ? LOW1 : LOW0));
            default: line_oe = 1'b0;
        endcase
    end

    // Ending events, valid in the last cycle of each operation.
    assign ev_brk  = (state_q == S_BRK) && (timer_q == BRK_LAST);
    assign ev_tx   = (state_q == S_TX) && (timer_q == SLOT_LAST) && (bit_q == 3'd7);
    assign ev_rx   = (state_q == S_RX_HIGH) && line_s && (bit_q == 3'd7);
    assign ev_rxto = (timer_q == WAIT_LAST) &&
                     (((state_q == S_RX_LOW) && line_s) || ((state_q == S_RX_HIGH) && !line_s));
    assign rx_byte = shreg_q;
endmodule

// File: rtl/slw_master.sv
// Top of the single-wire byte bus master: register file, wire synchronizer
// and transaction sequencer. Timing parameters are in microseconds and are
// scaled by CYC_PER_US functional clock cycles.
module slw_master
    import slw_pkg::*;
#(
    parameter int REV_MAJOR   = 2,
    parameter int REV_MINOR   = 1,
    parameter int CYC_PER_US  = 1,
    parameter int BREAK_US    = 190,
    parameter int RECOVER_US  = 40,
    parameter int SLOT_US     = 200,
    parameter int LOW1_US     = 40,
    parameter int LOW0_US     = 140,
    parameter int SAMPLE_US   = 100,
    parameter int RX_WAIT_US  = 500,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       line_oe,
    input  logic       line_in,
    output logic       irq
);
    localparam logic [7:0] REV_ID = {4'(REV_MAJOR), 4'(REV_MINOR)};

    xfer_e      start_kind;
    logic [7:0] tx_byte;
    logic [7:0] rx_byte;
    logic [7:0] ctl_q;
    logic [2:0] flags_q;
    logic       soft_rst;
    logic       line_s;
    logic       ev_brk, ev_tx, ev_rx, ev_rxto;

    slw_regs #(.REV_ID(REV_ID)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_brk(ev_brk), .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_rxto(ev_rxto),
        .rx_byte(rx_byte), .start_kind(start_kind), .tx_byte(tx_byte),
        .ctl_q(ctl_q), .flags_q(flags_q), .soft_rst(soft_rst), .irq(irq)
    );

    slw_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_in(line_in), .d_out(line_s)
    );

    slw_seq #(
        .BRK_LOW_CYC(BREAK_US * CYC_PER_US), .BRK_REC_CYC(RECOVER_US * CYC_PER_US),
        .SLOT_CYC(SLOT_US * CYC_PER_US), .LOW1_CYC(LOW1_US * CYC_PER_US),
        .LOW0_CYC(LOW0_US * CYC_PER_US), .SMP_CYC(SAMPLE_US * CYC_PER_US),
        .RXWAIT_CYC(RX_WAIT_US * CYC_PER_US)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .abort(soft_rst), .start_kind(start_kind),
        .tx_byte(tx_byte), .line_s(line_s), .line_oe(line_oe),
        .ev_brk(ev_brk), .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_rxto(ev_rxto),
        .rx_byte(rx_byte)
    );
endmodule

// File: rtl/slw_master_chk.sv
// Property checker for slw_master, attached by bind. Observes the register
// interface, the wire, the control and flag registers and the sequencer events.
module slw_master_chk
    import slw_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] reg_addr,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [7:0] reg_wdata,
    input logic       line_oe,
    input logic [7:0] ctl,
    input logic [2:0] flags,
    input logic       ev_brk,
    input logic       ev_tx,
    input logic       ev_rx,
    input logic       ev_rxto
);
    logic srst, ev_any;
    assign srst   = reg_wr && (reg_addr == A_CFG) && reg_wdata[C_SRST];
    assign ev_any = ev_brk || ev_tx || ev_rx || ev_rxto;

    // R3
    wire_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe |-> ctl[B_GO]);

    // R8
    go_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTL && !reg_wdata[B_CLKEN] && !ctl[B_GO]) |=> !ctl[B_GO]);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[B_GO] && reg_wr && reg_addr == A_CTL && !ev_any)
        |=> (ctl[B_GO] && ctl[B_INIT] == $past(ctl[B_INIT]) && ctl[B_DIR] == $past(ctl[B_DIR])));

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_FLG && !ev_any && !srst) |=> (flags == 3'b000));

    // R2
    brk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_brk && !srst) |=> (flags[F_TMO] && !ctl[B_INIT] && !ctl[B_GO]));

    // R10
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!line_oe && ctl == 8'h00 && flags == 3'b000));
endmodule

bind slw_master slw_master_chk chk_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .line_oe(line_oe),
    .ctl(ctl_q), .flags(flags_q), .ev_brk(ev_brk), .ev_tx(ev_tx),
    .ev_rx(ev_rx), .ev_rxto(ev_rxto)
);

// File: tb/slw_master_tb_top.sv
// Bench: a queue of expected wire levels, built from the requirements, is
// compared with line_oe and irq on every clock; a behavioural slave answers reads.
module slw_master_tb_top;
    localparam int T_BRK = 190, T_REC = 40, T_SLOT = 200, T_L1 = 40, T_L0 = 140, T_WAIT = 500;
    localparam logic [4:0] O_REV = 5'h00, O_TXD = 5'h04, O_RXD = 5'h08, O_CTL = 5'h0C,
                           O_FLG = 5'h10, O_CFG = 5'h14, O_STA = 5'h18;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic [4:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       line_oe, line_in, irq;
    logic       slave_pull = 1'b0;

    assign line_in = ~(line_oe | slave_pull);

    slw_master dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_oe(line_oe), .line_in(line_in),
        .irq(irq)
    );

    int   n_run = 0, n_fail = 0;
    bit   exp_q[$];
    bit   post_chk = 1'b0;
    bit   exp_ien = 1'b0;
    int   arm_kind = 0;
    logic [7:0] arm_byte = '0;

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Load the expected wire waveform of the operation just started.
    task automatic load_model();
        if (arm_kind == 1) begin
            for (int i = 0; i < T_BRK; i++) exp_q.push_back(1'b1);
            for (int i = 0; i < T_REC; i++) exp_q.push_back(1'b0);
        end else if (arm_kind == 2) begin
            for (int b = 0; b < 8; b++) begin
                int lo;
                lo = arm_byte[b] ? T_L1 : T_L0;
                for (int i = 0; i < lo; i++) exp_q.push_back(1'b1);
                for (int i = lo; i < T_SLOT; i++) exp_q.push_back(1'b0);
            end
        end
        arm_kind = 0;
    endtask

    // Per-clock comparison against the reference waveform (R2, R3, R7).
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            bit e;
            e = exp_q.pop_front();
            check("R3/R2 wire level", line_oe, e);
            check("R7 irq low while running", irq, 0);
            if (exp_q.size() == 0) post_chk = 1'b1;
        end else if (post_chk) begin
            check("R7 irq after completion", irq, exp_ien);
            post_chk = 1'b0;
        end
    end

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        load_model();
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [7:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        #3;
    endtask

    // Behavioural slave: answers a read with one byte, least significant bit first.
    task automatic slave_send(input logic [7:0] b, input int dly);
        repeat (dly) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            int lo;
            lo = b[i] ? T_L1 : T_L0;
            slave_pull = 1'b1;
            repeat (lo) @(negedge clk);
            slave_pull = 1'b0;
            repeat (T_SLOT - lo) @(negedge clk);
        end
    endtask

    task automatic wait_irq(input int limit);
        int cnt;
        cnt = 0;
        while (!irq && cnt < limit) begin
            @(posedge clk);
            cnt++;
        end
        #1;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        peek(O_REV, v); check("R1 revision", v, 8'h21);
        peek(O_CTL, v); check("R1 control", v, 0);
        peek(O_FLG, v); check("R1 flags", v, 0);
        peek(O_TXD, v); check("R1 tx data", v, 0);
        peek(O_CFG, v); check("R1 config", v, 0);
        peek(O_STA, v); check("R1 reset done", v, 1);
        check("R1 irq", irq, 0);
        check("R1 wire", line_oe, 0);

        // R8 start refused without clock enable
        wr(O_CTL, 8'h50);
        peek(O_CTL, v); check("R8 start bit", v, 8'h40);
        repeat (20) @(posedge clk);
        #1 check("R8 wire idle", line_oe, 0);
        check("R8 no irq", irq, 0);

        // R2 init pulse with interrupt enabled
        wr(O_CTL, 8'h60);
        exp_ien = 1'b1;
        arm_kind = 1;
        wr(O_CTL, 8'h74);
        peek(O_CTL, v); check("R2 running control", v, 8'h74);
        drain();
        rd(O_FLG, v); check("R2 timeout flag", v, 8'h01);
        peek(O_CTL, v); check("R2 init and start cleared", v, 8'h60);
        check("R6 irq after flag read", irq, 0);
        rd(O_FLG, v); check("R6 cleared on read", v, 0);

        // R3 byte writes, second one with a start write while busy (R9)
        for (int k = 0; k < 2; k++) begin
            logic [7:0] b;
            b = (k == 0) ? 8'hA5 : 8'h3C;
            wr(O_TXD, b);
            arm_kind = 2; arm_byte = b;
            wr(O_CTL, 8'h70);
            if (k == 1) begin
                repeat (300) @(posedge clk);
                wr(O_CTL, 8'h76);
                peek(O_CTL, v); check("R9 busy write ignored", v, 8'h70);
            end
            drain();
            rd(O_FLG, v); check("R3 transmit complete", v, 8'h04);
            peek(O_CTL, v); check("R3 start cleared", v, 8'h60);
        end

        // R4 byte reads with two patterns
        for (int k = 0; k < 2; k++) begin
            logic [7:0] b;
            b = (k == 0) ? 8'h5A : 8'h81;
            wr(O_CTL, 8'h62);
            wr(O_CTL, 8'h72);
            fork
                slave_send(b, 25);
                wait_irq(4000);
            join
            rd(O_FLG, v); check("R4 receive complete", v, 8'h02);
            rd(O_RXD, v); check("R4 received byte", v, b);
            peek(O_CTL, v); check("R4 start cleared, direction kept", v, 8'h62);
        end

        // R5 read timeout with exact irq timing
        wr(O_CTL, 8'h72);
        repeat (T_WAIT - 1) @(posedge clk);
        #1 check("R5 irq not yet", irq, 0);
        @(posedge clk);
        #1 check("R5 irq on timeout", irq, 1);
        rd(O_FLG, v); check("R5 timeout flag", v, 8'h01);
        peek(O_CTL, v); check("R5 start cleared", v, 8'h62);

        // R6 flag raised in the same cycle as a flag read survives
        wr(O_CTL, 8'h72);
        repeat (T_WAIT - 1) @(posedge clk);
        rd(O_FLG, v); check("R6 read before event", v, 0);
        check("R6 event kept irq", irq, 1);
        rd(O_FLG, v); check("R6 event kept flag", v, 8'h01);

        // R7 masking and sticky accumulation
        exp_ien = 1'b0;
        arm_kind = 1;
        wr(O_CTL, 8'h34);
        drain();
        wr(O_TXD, 8'h0F);
        arm_kind = 2; arm_byte = 8'h0F;
        wr(O_CTL, 8'h30);
        drain();
        check("R7 masked irq", irq, 0);
        wr(O_CTL, 8'h60);
        check("R7 irq on enable with pending flags", irq, 1);
        rd(O_FLG, v); check("R6 accumulated flags", v, 8'h05);
        check("R7 irq after clear", irq, 0);

        // R11 auto-idle bit
        wr(O_CFG, 8'h01);
        peek(O_CFG, v); check("R11 auto-idle readback", v, 8'h01);

        // R10 soft reset aborts a running write
        wr(O_TXD, 8'hFF);
        wr(O_CTL, 8'h70);
        repeat (10) @(posedge clk);
        #1 check("R10 wire low before reset", line_oe, 1);
        wr(O_CFG, 8'h02);
        peek(O_STA, v); check("R10 reset done low", v, 0);
        check("R10 wire released", line_oe, 0);
        @(posedge clk);
        #1 peek(O_STA, v); check("R10 reset done high", v, 1);
        peek(O_CTL, v); check("R10 control cleared", v, 0);
        peek(O_CFG, v); check("R10 config cleared", v, 0);
        peek(O_TXD, v); check("R10 tx data cleared", v, 0);
        repeat (50) @(posedge clk);
        #1 check("R10 wire stays released", line_oe, 0);

        finish_run();
    end
endmodule